// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer that steps a multi-channel analog-to-digital converter through a conversion sequence. Software writes a control word that carries four things: a special-channel flag, a continuous-scan flag, a multi-channel flag and a 4-bit start channel. That write cancels whatever sequence is running. It then either starts a fresh sequence at once or, in external-trigger mode, only arms the block. For each conversion the block issues a one-cycle start pulse with a channel number and waits for a one-cycle done pulse from the converter. It keeps the index of the result slot being filled.

Three settings are held by the surrounding configuration logic and are read live by the block:

- a wrap channel, after which multi-channel stepping returns to channel 0;
- a sequence length of 1 to 16 conversions;
- an external-trigger enable.

In external-trigger mode each qualified trigger runs exactly one sequence, and the scan flag is disregarded.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, conv_start, seq_done, conv_special, conv_chan and slot_idx are all 0, and the stored control fields are 0.
- R2: With ext_trig_en low, a ctl_we cycle makes conv_start high in the next cycle, with conv_chan equal to ctl_code and slot_idx 0. This holds even when a sequence was in progress, and that sequence is abandoned.
- R3: With the multi-channel flag at 0, every conversion of the sequence presents the written channel code.
- R4: With the multi-channel flag at 1, each conversion after the first uses the previous channel plus one.
- R5: With the multi-channel flag at 1, the conversion that follows the channel equal to wrap_sel uses channel 0.
- R6: When the start channel is above wrap_sel, stepping runs up to channel 15 and rolls over to channel 0.
- R7: A sequence holds seq_len conversions, and a seq_len of 0 means 16. slot_idx counts 0, 1, 2 and so on. seq_done is a one-cycle pulse in the cycle after the done pulse of the last conversion.
- R8: With the scan flag at 1 and ext_trig_en low, the cycle that shows seq_done also shows conv_start for a new sequence, with the start channel and slot_idx 0.
- R9: With the scan flag at 0, busy falls together with seq_done, and no further conv_start appears until the next write or trigger.
- R10: With ext_trig_en high, a write only arms the block: no conversion starts. Each ext_trig seen while idle gives conv_start in the next cycle and runs exactly one sequence, whatever the scan flag says.
- R11: ext_trig is ignored before the first control write after reset, and also while a sequence is busy.
- R12: When the special-channel flag is 1, conv_special is high during every conversion of the sequence, and channel stepping is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_special | input | 1 | Special-channel flag of the write |
| ctl_scan | input | 1 | Continuous-scan flag of the write |
| ctl_multi | input | 1 | Multi-channel flag of the write |
| ctl_code | input | 4 | Start channel code of the write |
| wrap_sel | input | 4 | Last channel before stepping returns to 0 |
| seq_len | input | 4 | Conversions per sequence, where 0 selects 16 |
| ext_trig_en | input | 1 | External-trigger mode enable |
| ext_trig | input | 1 | External trigger event, one cycle |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | Start of a conversion (sampling begins), one cycle |
| conv_chan | output | 4 | Channel of the current conversion |
| conv_special | output | 1 | Current conversion targets a special channel |
| slot_idx | output | 4 | Result slot of the current conversion |
| seq_done | output | 1 | Last conversion of the sequence finished, one cycle |
| busy | output | 1 | A sequence is in progress |

## Verification
A wrong channel register or a wrong wrap compare appears on conv_chan together with the very next conv_start, which is one cycle after the converter's done pulse. A slot counter that is off shows at once on slot_idx, and one sequence later as a seq_done pulse that comes early or late. A bad arming bit or a bad scan decision shows as a conv_start that is missing or unexpected, in the cycle after the write, trigger or final done that should have decided it. The bench therefore samples each of these one cycle after the causing edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adc_chan_step.sv
module adc_chan_step #(
    parameter int CHAN_W = 4
) (
    input  logic [CHAN_W-1:0] cur_i,
    input  logic [CHAN_W-1:0] wrap_i,
    input  logic              multi_i,
    output logic [CHAN_W-1:0] nxt_o
);

    // Stepping rolls over naturally at the top code; the wrap compare returns to 0 earlier.
    always_comb begin
        if (!multi_i) begin
            nxt_o = cur_i;
        end else if (cur_i == wrap_i) begin
            nxt_o = '0;
        end else begin
            nxt_o = cur_i + CHAN_W'(1);
        end
    end

endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic trig_en_i,
    input  logic trig_i,
    input  logic idle_i,
    output logic fire_o,
    output logic armed_o
);

    typedef struct packed {
        logic armed;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d       = gate_q;
        gate_d.armed = gate_q.armed | arm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign fire_o  = trig_en_i && gate_q.armed && trig_i && idle_i;
    assign armed_o = gate_q.armed;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_special,
    input  logic              ctl_scan,
    input  logic              ctl_multi,
    input  logic [CHAN_W-1:0] ctl_code,
    input  logic [CHAN_W-1:0] wrap_sel,
    input  logic [LEN_W-1:0]  seq_len,
    input  logic              ext_trig_en,
    input  logic              ext_trig,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_special,
    output logic [LEN_W-1:0]  slot_idx,
    output logic              seq_done,
    output logic              busy
);

    typedef struct packed {
        seq_state_e        state;
        logic [CHAN_W-1:0] chan;
        logic [LEN_W-1:0]  slot;
        logic              start;
        logic              done;
        logic              special;
        logic              scan;
        logic              multi;
        logic [CHAN_W-1:0] code;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CHAN_W-1:0] chan_nxt;
    logic [LEN_W-1:0]  last_slot;
    logic              trig_fire;
    logic              trig_armed;
    logic              repeat_seq;

    adc_chan_step #(.CHAN_W(CHAN_W)) step_i (
        .cur_i   (seq_q.chan),
        .wrap_i  (wrap_sel),
        .multi_i (seq_q.multi),
        .nxt_o   (chan_nxt)
    );

    adc_trig_gate gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (ctl_we),
        .trig_en_i (ext_trig_en),
        .trig_i    (ext_trig),
        .idle_i    ((seq_q.state == SEQ_IDLE) && !ctl_we),
        .fire_o    (trig_fire),
        .armed_o   (trig_armed)
    );

    // A length of 0 wraps to the all-ones slot, so 16 conversions are run.
    assign last_slot  = seq_len - LEN_W'(1);
    assign repeat_seq = seq_q.scan && !ext_trig_en;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.done  = 1'b0;
        if (ctl_we) begin
            seq_d.special = ctl_special;
            seq_d.scan    = ctl_scan;
            seq_d.multi   = ctl_multi;
            seq_d.code    = ctl_code;
            seq_d.chan    = ctl_code;
            seq_d.slot    = '0;
            if (ext_trig_en) begin
                seq_d.state = SEQ_IDLE;
            end else begin
                seq_d.state = SEQ_CONV;
                seq_d.start = 1'b1;
            end
        end else if (trig_fire) begin
            seq_d.chan  = seq_q.code;
            seq_d.slot  = '0;
            seq_d.state = SEQ_CONV;
            seq_d.start = 1'b1;
        end else if (seq_q.state == SEQ_CONV && conv_done) begin
            if (seq_q.slot == last_slot) begin
                seq_d.done = 1'b1;
                if (repeat_seq) begin
                    seq_d.chan  = seq_q.code;
                    seq_d.slot  = '0;
                    seq_d.start = 1'b1;
                end else begin
                    seq_d.state = SEQ_IDLE;
                end
            end else begin
                seq_d.chan  = chan_nxt;
                seq_d.slot  = seq_q.slot + LEN_W'(1);
                seq_d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_start   = seq_q.start;
    assign conv_chan    = seq_q.chan;
    assign conv_special = seq_q.special && (seq_q.state == SEQ_CONV);
    assign slot_idx     = seq_q.slot;
    assign seq_done     = seq_q.done;
    assign busy         = (seq_q.state == SEQ_CONV);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !seq_done && seq_q.multi &&
         $past(busy && conv_done && !ctl_we && !trig_fire && conv_chan == wrap_sel))
        |-> (conv_chan == '0));

    // R3
    single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_q.multi) |-> (conv_chan == seq_q.code));

    // R11
    unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_armed |-> !busy);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/100ps
module adc_seq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, ctl_special = 1'b0, ctl_scan = 1'b0, ctl_multi = 1'b0;
    logic [3:0] ctl_code = '0, wrap_sel = '0, seq_len = '0;
    logic       ext_trig_en = 1'b0, ext_trig = 1'b0, conv_done = 1'b0;
    logic       conv_start, conv_special, seq_done, busy;
    logic [3:0] conv_chan, slot_idx;

    int nchecks = 0;
    int nfail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_special(ctl_special),
        .ctl_scan(ctl_scan), .ctl_multi(ctl_multi), .ctl_code(ctl_code),
        .wrap_sel(wrap_sel), .seq_len(seq_len), .ext_trig_en(ext_trig_en),
        .ext_trig(ext_trig), .conv_done(conv_done), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_special(conv_special), .slot_idx(slot_idx),
        .seq_done(seq_done), .busy(busy)
    );

    // vector fields: special[13] multi[12] code[11:8] wrap[7:4] len[3:0]
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 1'b0, 4'd5,  4'd15, 4'd3},
        {1'b0, 1'b1, 4'd2,  4'd15, 4'd4},
        {1'b0, 1'b1, 4'd6,  4'd7,  4'd4},
        {1'b0, 1'b1, 4'd12, 4'd3,  4'd6},
        {1'b1, 1'b1, 4'd0,  4'd2,  4'd5},
        {1'b0, 1'b1, 4'd0,  4'd15, 4'd0},
        {1'b0, 1'b0, 4'd9,  4'd0,  4'd1},
        {1'b1, 1'b0, 4'd15, 4'd15, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] next_chan(input logic [3:0] c, input logic mu,
                                             input logic [3:0] w);
        if (!mu) return c;
        if (c == w) return 4'd0;
        return c + 4'd1;
    endfunction

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic sp, input logic sc, input logic mu, input logic [3:0] code);
        ctl_special = sp; ctl_scan = sc; ctl_multi = mu; ctl_code = code;
        ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    // Expects conv_start visible now; finishes one cycle after the done pulse.
    task automatic run_conv(input int ch, input int slot, input logic sp, input string req);
        chk(conv_start == 1'b1, req, conv_start, 1);
        chk(conv_chan == ch[3:0], req, conv_chan, ch);
        chk(slot_idx == slot[3:0], "R7", slot_idx, slot);
        chk(conv_special == sp, "R12", conv_special, sp);
        @(negedge clk);
        chk(conv_start == 1'b0 && busy == 1'b1, req, {conv_start, busy}, 1);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        apply_reset();
        // R1 reset state
        chk(busy == 0 && conv_start == 0 && seq_done == 0, "R1", {busy, conv_start, seq_done}, 0);
        chk(conv_chan == 0 && slot_idx == 0 && conv_special == 0, "R1", {conv_chan, slot_idx}, 0);

        // vector walk: single sequences
        foreach (VEC[v]) begin
            logic sp, mu;
            logic [3:0] code, ch;
            int n;
            string req;
            sp = VEC[v][13]; mu = VEC[v][12]; code = VEC[v][11:8];
            wrap_sel = VEC[v][7:4]; seq_len = VEC[v][3:0];
            n = (VEC[v][3:0] == 0) ? 16 : int'(VEC[v][3:0]);
            if (!mu) req = "R3";
            else if (code > wrap_sel) req = "R6";
            else if (wrap_sel != 4'd15) req = "R5";
            else req = "R4";
            do_write(sp, 1'b0, mu, code);
            ch = code;
            for (int i = 0; i < n; i++) begin
                run_conv(ch, i, sp, (i == 0) ? "R2" : req);
                ch = next_chan(ch, mu, wrap_sel);
            end
            chk(seq_done == 1'b1, "R7", seq_done, 1);
            chk(busy == 1'b0 && conv_start == 1'b0, "R9", {busy, conv_start}, 0);
            @(negedge clk);
            chk(seq_done == 1'b0, "R7", seq_done, 0);
        end

        // R9 stays idle without new write
        repeat (5) @(negedge clk);
        chk(conv_start == 0 && busy == 0, "R9", {conv_start, busy}, 0);

        // R8 continuous scan restarts immediately
        wrap_sel = 4'd15; seq_len = 4'd2;
        do_write(1'b0, 1'b1, 1'b1, 4'd3);
        run_conv(3, 0, 1'b0, "R2");
        run_conv(4, 1, 1'b0, "R4");
        chk(seq_done == 1'b1, "R8", seq_done, 1);
        chk(conv_start == 1'b1 && conv_chan == 4'd3 && slot_idx == 0, "R8", conv_chan, 3);
        run_conv(3, 0, 1'b0, "R8");
        // R2 abort mid-sequence by a new write
        wrap_sel = 4'd15; seq_len = 4'd1;
        do_write(1'b0, 1'b0, 1'b0, 4'd7);
        chk(seq_done == 1'b0, "R2", seq_done, 0);
        run_conv(7, 0, 1'b0, "R2");
        chk(seq_done == 1'b1 && busy == 1'b0, "R9", {seq_done, busy}, 2);

        // External trigger mode from a fresh reset
        ext_trig_en = 1'b1;
        apply_reset();
        pulse_trig();
        chk(conv_start == 0 && busy == 0, "R11", {conv_start, busy}, 0);
        wrap_sel = 4'd15; seq_len = 4'd2;
        do_write(1'b0, 1'b1, 1'b1, 4'd4);
        chk(conv_start == 0 && busy == 0, "R10", {conv_start, busy}, 0);
        pulse_trig();
        chk(conv_start == 1 && conv_chan == 4'd4 && slot_idx == 0, "R10", conv_chan, 4);
        // trigger while busy is ignored
        pulse_trig();
        chk(conv_start == 0 && conv_chan == 4'd4, "R11", conv_chan, 4);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(conv_start == 1 && conv_chan == 4'd5 && slot_idx == 1, "R10", conv_chan, 5);
        run_conv(5, 1, 1'b0, "R10");
        chk(seq_done == 1'b1 && conv_start == 1'b0 && busy == 1'b0, "R10", {seq_done, conv_start, busy}, 4);
        repeat (4) @(negedge clk);
        chk(conv_start == 0 && busy == 0, "R10", {conv_start, busy}, 0);
        // a second trigger runs one more sequence
        pulse_trig();
        run_conv(4, 0, 1'b0, "R10");
        run_conv(5, 1, 1'b0, "R10");
        chk(seq_done == 1'b1 && busy == 1'b0, "R10", {seq_done, busy}, 2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

endmodule